// File: doc/BRIEF.md
# Stream-fed memory preload controller

This block fills an on-chip RAM from a host-to-device word stream before the processing logic that uses the RAM is allowed to start. The host programs a 64-bit base register (`host_base`) and pushes words over a valid/ready stream. The block writes those words to consecutive RAM addresses. Whenever the stream goes quiet, it adds the number of words just written to a cumulative 64-bit counter (`count_out`). The host polls that counter to learn that its block of data has landed.

To load another region, the host writes a different base value. To finish loading, it writes the all-ones value. The block then raises `run_en`, stops accepting stream data, and keeps `run_en` high until reset. The downstream logic reads the RAM through a registered read port.

The RAM depth must be a power of two. Base values are reduced to the low address bits, so addresses wrap modulo the depth.

Top module: `stream_preload`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `count_out`, `run_en`, the write pointer and the stored base copy. After that edge, `s_ready` is 0, `run_en` is 0 and `count_out` is 0.
- R2: Before any word is offered after reset, `s_ready` stays 0 and nothing is written. This holds even if `host_base` changes to a value other than all ones.
- R3: In the first cycle after reset in which `s_valid` is high, the block samples `host_base` as the write pointer. From the next cycle, each word accepted (`s_valid` and `s_ready` both high at an edge) is written at the pointer, and the pointer then advances by one.
- R4: The pointer is the low log2(DEPTH) bits of the sampled base and wraps from DEPTH-1 to 0. For example, base 254 with 4 words at depth 256 fills addresses 254, 255, 0 and 1.
- R5: A burst cycle in which `s_valid` is low is a dry cycle. At the edge ending that cycle, `count_out` grows by the number of words accepted since the previous dry cycle, and `s_ready` drops to 0.
- R6: `count_out` is cumulative across bursts and never decreases before reset.
- R7: After a dry cycle, new words offered while `host_base` still holds the last sampled value continue at the following address. Rewriting the same base value starts no new burst.
- R8: After a dry cycle, a `host_base` value different from the last sampled one, other than all ones, reloads the pointer with the new base. Later words are written from there.
- R9: A `host_base` of all ones, seen when the block is idle or in a dry cycle, sets `run_en` at the next edge. From then on `s_ready` stays 0, `count_out` and the RAM are left unchanged, and `run_en` stays 1 until reset.
- R10: When `host_base` changes during a burst and the next dry cycle sees the changed value, the count update and the base reload (or the end of loading) happen at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_base | input | REG_W | Host base register: burst start address, or all ones to end loading |
| count_out | output | REG_W | Cumulative count of words written, updated in dry cycles |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Block accepts a stream word this cycle |
| s_data | input | DATA_W | Stream word |
| run_en | output | 1 | Loading finished; downstream logic may run |
| rd_addr | input | log2(DEPTH) | RAM read address for downstream logic |
| rd_data | output | DATA_W | RAM read data, one cycle after `rd_addr` |

## Verification
The dry cycle that publishes a burst's count can be the same cycle that acts on a new `host_base`, whether that value is a new base or the end-of-load value. The bench provokes this by changing `host_base` together with the final word of a burst and then dropping `s_valid`. It then checks, after that single edge, that the count already includes the burst and that either `run_en` has risen or the next words land at the new base rather than after the old burst.

// File: rtl/preload_pkg.sv
package preload_pkg;

  // Controller phases: waiting for first word, taking words, stream dry, released
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_BURST = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } pl_state_e;

endpackage

// File: rtl/preload_mem.sv
module preload_mem #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 256,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/preload_seq.sv
module preload_seq
  import preload_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic [REG_W-1:0] host_base,
  output pl_state_e        state,
  output logic             s_ready,
  output logic             load_base,
  output logic             dry_evt,
  output logic             end_evt,
  output logic             run_en
);

  localparam logic [REG_W-1:0] END_CODE = {REG_W{1'b1}};

  function automatic logic is_end_cmd(input logic [REG_W-1:0] v);
    return v == END_CODE;
  endfunction

  logic [REG_W-1:0] last_base;
  logic             addr_changed;
  logic             end_req;
  pl_state_e        state_nx;

  assign addr_changed = (host_base != last_base);
  assign end_req      = is_end_cmd(host_base);
  assign s_ready      = (state == ST_BURST);

  always_comb begin
    state_nx  = state;
    load_base = 1'b0;
    dry_evt   = 1'b0;
    end_evt   = 1'b0;
    case (state)
      ST_ARMED: begin
        if (end_req) begin
          end_evt  = 1'b1;
          state_nx = ST_DONE;
        end else if (s_valid) begin
          load_base = 1'b1;
          state_nx  = ST_BURST;
        end
      end
      ST_BURST: begin
        if (!s_valid) begin
          dry_evt = 1'b1;
          if (addr_changed && end_req) begin
            end_evt  = 1'b1;
            state_nx = ST_DONE;
          end else if (addr_changed) begin
            load_base = 1'b1;
            state_nx  = ST_BURST;
          end else begin
            state_nx = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (addr_changed && end_req) begin
          end_evt  = 1'b1;
          state_nx = ST_DONE;
        end else if (addr_changed) begin
          load_base = 1'b1;
          state_nx  = ST_BURST;
        end else if (s_valid) begin
          state_nx = ST_BURST;
        end
      end
      default: state_nx = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ARMED;
      last_base <= '0;
      run_en    <= 1'b0;
    end else begin
      state <= state_nx;
      if (load_base) last_base <= host_base;
      if (end_evt)   run_en    <= 1'b1;
    end
  end

  AST_ARMED_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> !s_ready); // R2
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    run_en |=> run_en); // R9
  AST_RUN_BLOCKS_STREAM: assert property (@(posedge clk) disable iff (rst)
    run_en |-> !s_ready); // R9
  AST_SAME_BASE_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WAIT) && !addr_changed) |-> !load_base); // R7

endmodule

// File: rtl/preload_track.sv
module preload_track #(
  parameter int REG_W = 64,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_base,
  input  logic [AW-1:0]    base_lo,
  input  logic             wr_fire,
  input  logic             dry_evt,
  output logic [AW-1:0]    wr_ptr,
  output logic [REG_W-1:0] burst_cnt,
  output logic [REG_W-1:0] count_out
);

  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  // Pointer step with explicit wrap at the last slot
  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // Publishing merges the burst tally into the running total
  function automatic logic [REG_W-1:0] total_merge(input logic [REG_W-1:0] total,
                                                   input logic [REG_W-1:0] part);
    return total + part;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      burst_cnt <= '0;
      count_out <= '0;
    end else begin
      if (load_base)    wr_ptr <= base_lo;
      else if (wr_fire) wr_ptr <= ptr_next(wr_ptr);
      if (dry_evt) begin
        count_out <= total_merge(count_out, burst_cnt);
        burst_cnt <= '0;
      end else if (wr_fire) begin
        burst_cnt <= burst_cnt + 1'b1;
      end
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (wr_ptr == ptr_next($past(wr_ptr)))); // R3
  AST_PUBLISH_SUM: assert property (@(posedge clk) disable iff (rst)
    dry_evt |=> (count_out == $past(count_out) + $past(burst_cnt))); // R5
  AST_COUNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_out >= $past(count_out))); // R6

endmodule

// File: rtl/stream_preload.sv
module stream_preload
  import preload_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 64,
  parameter int DEPTH  = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [REG_W-1:0]         host_base,
  output logic [REG_W-1:0]         count_out,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [DATA_W-1:0]        s_data,
  output logic                     run_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int AW = $clog2(DEPTH);

  pl_state_e        state;
  logic             load_base;
  logic             dry_evt;
  logic             end_evt;
  logic             wr_fire;
  logic [AW-1:0]    wr_ptr;
  logic [REG_W-1:0] burst_cnt;

  assign wr_fire = s_valid && s_ready;

  preload_seq #(.REG_W(REG_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .host_base (host_base),
    .state     (state),
    .s_ready   (s_ready),
    .load_base (load_base),
    .dry_evt   (dry_evt),
    .end_evt   (end_evt),
    .run_en    (run_en)
  );

  preload_track #(.REG_W(REG_W), .DEPTH(DEPTH), .AW(AW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .load_base (load_base),
    .base_lo   (host_base[AW-1:0]),
    .wr_fire   (wr_fire),
    .dry_evt   (dry_evt),
    .wr_ptr    (wr_ptr),
    .burst_cnt (burst_cnt),
    .count_out (count_out)
  );

  preload_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_ptr),
    .wdata (s_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  AST_LOAD_APART_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_base, wr_fire})); // R8
  AST_DRY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    dry_evt |-> !wr_fire); // R5
  AST_END_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> (!s_ready && (state == ST_DONE))); // R9

endmodule

// File: tb/stream_preload_test.sv
module stream_preload_test;

  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam logic [63:0] ALL_ONES = {64{1'b1}};

  typedef struct packed {
    logic [63:0] base;
    logic [7:0]  n;
    logic [63:0] seed;
  } vec_t;

  // base, word count, data seed
  localparam vec_t VECS [5] = '{
    '{64'd16,           8'd5, 64'h0A00_0000_0000_0000}, // R3 first burst
    '{64'd16,           8'd3, 64'h0B00_0000_0000_0000}, // R7 same base continues
    '{64'd100,          8'd4, 64'h0C00_0000_0000_0000}, // R8 new base
    '{64'd254,          8'd4, 64'h0D00_0000_0000_0000}, // R4 wrap
    '{64'h1_0000_0020,  8'd2, 64'h0E00_0000_0000_0000}  // R4 low bits only
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   host_base = '0;
  logic [63:0]   count_out;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [63:0]   s_data = '0;
  logic          run_en;
  logic [AW-1:0] rd_addr = '0;
  logic [63:0]   rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [63:0]    model_mem [DEPTH];
  logic [DEPTH-1:0] touched = '0;
  int             model_ptr = 0;
  logic [63:0]    model_last = '0;
  logic [63:0]    exp_cnt = '0;

  always #5 clk = ~clk;

  stream_preload uut (
    .clk(clk), .rst(rst), .host_base(host_base), .count_out(count_out),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .run_en(run_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Offer one word and hold it until an edge with s_ready high takes it
  task automatic push_word(input logic [63:0] d);
    logic taken;
    s_valid = 1'b1;
    s_data  = d;
    taken   = 1'b0;
    while (!taken) begin
      taken = s_ready;
      tick();
    end
  endtask

  function automatic logic [63:0] word_of(input logic [63:0] seed, input int i);
    return seed + 64'(i) * 64'h0000_0001_0000_1111;
  endfunction

  task automatic model_put(input logic [63:0] d);
    model_mem[model_ptr] = d;
    touched[model_ptr]   = 1'b1;
    model_ptr            = (model_ptr + 1) % DEPTH;
  endtask

  task automatic run_burst(input logic [63:0] base, input int n, input logic [63:0] seed);
    if (base != model_last) begin
      model_ptr  = int'(base % 64'(DEPTH));
      model_last = base;
    end
    host_base = base;
    for (int i = 0; i < n; i++) begin
      model_put(word_of(seed, i));
      push_word(word_of(seed, i));
    end
    s_valid = 1'b0;
    tick();
    tick();
    exp_cnt = exp_cnt + 64'(n);
  endtask

  task automatic read_word(input int a, output logic [63:0] d);
    rd_addr = AW'(a);
    tick();
    d = rd_data;
  endtask

  task automatic verify_mem(input string tag);
    logic [63:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      if (touched[a]) begin
        read_word(a, d);
        chk(tag, d, model_mem[a]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) tick();
    rst = 1'b0;
    // R1: state after reset
    chk("R1 s_ready", 64'(s_ready), 64'd0);
    chk("R1 run_en", 64'(run_en), 64'd0);
    chk("R1 count_out", count_out, 64'd0);

    // R2: idle without data, even with a changed base
    host_base = 64'd77;
    repeat (5) tick();
    chk("R2 s_ready idle", 64'(s_ready), 64'd0);
    chk("R2 count idle", count_out, 64'd0);

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      run_burst(VECS[v].base, int'(VECS[v].n), VECS[v].seed);
      chk("R5 R6 count after burst", count_out, exp_cnt);
      chk("R5 s_ready after dry", 64'(s_ready), 64'd0);
    end
    verify_mem("R3 R4 R7 R8 ram contents");

    // R10: base change lands in the dry cycle that publishes
    host_base = 64'd200;
    model_ptr = 200;
    model_last = 64'd200;
    for (int i = 0; i < 3; i++) begin
      if (i == 2) host_base = 64'd210;
      model_put(word_of(64'h0F00, i));
      push_word(word_of(64'h0F00, i));
    end
    s_valid = 1'b0;
    tick();
    exp_cnt = exp_cnt + 64'd3;
    chk("R10 count at rebase edge", count_out, exp_cnt);
    model_ptr = 210;
    model_last = 64'd210;
    run_burst(64'd210, 2, 64'h1100);
    chk("R10 count after second part", count_out, exp_cnt);
    verify_mem("R10 rebase target");

    // R9: end of load from idle
    host_base = ALL_ONES;
    tick();
    chk("R9 run_en raised", 64'(run_en), 64'd1);
    chk("R9 s_ready low", 64'(s_ready), 64'd0);
    s_valid = 1'b1;
    s_data  = 64'hDEAD_BEEF_0000_0001;
    repeat (4) tick();
    chk("R9 s_ready stays low", 64'(s_ready), 64'd0);
    chk("R9 count frozen", count_out, exp_cnt);
    chk("R9 run_en held", 64'(run_en), 64'd1);
    s_valid = 1'b0;
    host_base = 64'd3;
    repeat (2) tick();
    chk("R9 run_en held after base change", 64'(run_en), 64'd1);
    verify_mem("R9 ram untouched");

    // R1 again, then R10 with end-of-load in the dry cycle
    rst = 1'b1;
    host_base = 64'd5;
    repeat (2) tick();
    rst = 1'b0;
    chk("R1 run_en cleared", 64'(run_en), 64'd0);
    chk("R1 count cleared", count_out, 64'd0);
    touched = '0;
    model_ptr = 5;
    for (int i = 0; i < 3; i++) begin
      if (i == 2) host_base = ALL_ONES;
      model_put(word_of(64'h2200, i));
      push_word(word_of(64'h2200, i));
    end
    s_valid = 1'b0;
    tick();
    chk("R10 count at end edge", count_out, 64'd3);
    chk("R10 run_en at end edge", 64'(run_en), 64'd1);
    read_word(7, d);
    chk("R10 last word stored", d, word_of(64'h2200, 2));
    verify_mem("R3 after second reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule